// File: doc/BRIEF.md
# Four-Channel Daisy-Chain Interrupt Controller

This block is the interrupt section of a four-channel counter/timer. Each channel reports a zero-count event. If that channel's enable is set, the event is held as a pending request. The four channels fill four neighbouring, fixed-priority positions in an external daisy chain. Channel 0 has the highest priority and channel 3 the lowest. The whole group is gated by the chain's incoming enable.

The block drives one active-low interrupt request shared by all channels and an outgoing enable for the devices further down the chain. When the processor acknowledges, the block puts the vector of the winning channel on its vector output. The vector is a programmed upper field followed by the two-bit channel number and a cleared bit 0. The block then marks that channel as under service. The service mark stays until a return-from-interrupt strobe arrives while the incoming enable is high. Until then the mark blocks that channel and every channel below it.

Top module: `ictl_daisy`

## Requirements
- R1: After reset no request is pending and no channel is under service: `int_n_o` is 1, `vec_oe_o` is 0 and `ieo_o` follows `iei_i`.
- R2: A one-cycle pulse on `zc_i[k]` while `ena_i[k]` is 1 makes channel k pending from the next cycle. With `iei_i` high and nothing blocking it, `int_n_o` then goes to 0.
- R3: A zero-count pulse on a channel whose enable is 0 sets no request: `int_n_o` stays 1 and `ieo_o` stays 1.
- R4: Channel 0 has the highest priority and channel 3 the lowest. An acknowledge serves the lowest-numbered pending channel that is not blocked.
- R5: While `vec_oe_o` is 1, `vec_o` equals {`vec_hi_i`, k[1:0], 1'b0}, where k is the granted channel.
- R6: While `iei_i` is 0, `int_n_o` is 1, `vec_oe_o` is 0 and `ieo_o` is 0. An acknowledge or return strobe given in that state changes no pending or service state.
- R7: `ieo_o` is 1 only when `iei_i` is 1 and no channel is pending or under service.
- R8: A channel under service blocks its own new requests and all lower-priority requests. A higher-priority channel can still raise `int_n_o` and be granted.
- R9: A `reti_i` pulse while `iei_i` is 1 clears the service mark of the highest-priority channel under service, and only that mark.
- R10: An acknowledge clears the granted channel's pending request. A new zero-count on that same channel in the same cycle keeps it pending.
- R11: `vec_oe_o` is 1 exactly in a cycle where `ack_i` and `iei_i` are 1 and some channel is eligible. Otherwise `vec_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| zc_i | input | NCH | Per-channel zero-count pulse |
| ena_i | input | NCH | Per-channel interrupt enable |
| iei_i | input | 1 | Daisy-chain incoming enable |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| vec_hi_i | input | VEC_W-3 | Programmed upper vector field |
| int_n_o | output | 1 | Shared active-low interrupt request |
| ieo_o | output | 1 | Daisy-chain outgoing enable |
| vec_o | output | VEC_W | Interrupt vector |
| vec_oe_o | output | 1 | Vector valid, high during a granted acknowledge |

## Verification
The assertions check a set of rules on every cycle:
- a disabled channel never becomes pending, and a fresh enabled zero-count always leaves its channel pending;
- the grant is at most one-hot and never lands on a channel under service;
- a taken acknowledge always sets the granted channel's service mark;
- a return strobe with no acknowledge in the same cycle removes exactly one mark;
- the outgoing enable and the request are never active together, and a low incoming enable silences all outputs.

Only the bench scenarios can show the rest: which channel wins when several are pending, the exact vector value, that a higher channel interrupts a lower one in service, that a return strobe given while the incoming enable is low is ignored, and that a pending request survives an ignored acknowledge.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
   // Vector bits [2:1] carry the channel number, bit 0 is always zero.
   localparam int SLOT_W = 2;
   localparam int MAX_CH = 1 << SLOT_W;
endpackage

// File: rtl/ictl_req_latch.sv
module ictl_req_latch #(
   parameter int NCH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] zc_i,
   input  logic [NCH-1:0] ena_i,
   input  logic [NCH-1:0] clr_i,
   output logic [NCH-1:0] pend_o
);
   generate
      for (genvar k = 0; k < NCH; k++) begin : g_ch
         always_ff @(posedge clk) begin
            if (!rst_n)
               pend_o[k] <= 1'b0;
            else if (zc_i[k] && ena_i[k])
               pend_o[k] <= 1'b1;
            else if (clr_i[k])
               pend_o[k] <= 1'b0;
         end

         // R3: a channel that is not enabled never picks up a request
         assert_disabled_quiet_R3 : assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(pend_o[k]) && !$past(zc_i[k] && ena_i[k])) |-> !pend_o[k]);

         // R10: a fresh enabled zero-count survives a same-cycle clear
         assert_set_wins_R10 : assert property (@(posedge clk) disable iff (!rst_n)
            $past(zc_i[k] && ena_i[k]) |-> pend_o[k]);
      end
   endgenerate
endmodule

// File: rtl/ictl_prio.sv
module ictl_prio
   import ictl_pkg::*;
#(
   parameter int NCH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    pend_i,
   input  logic [NCH-1:0]    srv_i,
   output logic [NCH-1:0]    grant_o,
   output logic              any_o,
   output logic [SLOT_W-1:0] idx_o
);
   logic [NCH:0] blk;

   assign blk[0] = 1'b0;

   generate
      for (genvar k = 0; k < NCH; k++) begin : g_chain
         assign grant_o[k] = pend_i[k] & ~srv_i[k] & ~blk[k];
         assign blk[k+1]   = blk[k] | pend_i[k] | srv_i[k];
      end
   endgenerate

   assign any_o = |grant_o;

   always_comb begin
      idx_o = '0;
      for (int k = NCH - 1; k >= 0; k--)
         if (grant_o[k]) idx_o = SLOT_W'(k);
   end

   // R4: at most one channel wins the chain
   assert_single_grant_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));

   // R8: no grant to a channel still under service
   assert_no_grant_in_service_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o & srv_i) == '0);
endmodule

// File: rtl/ictl_srv.sv
module ictl_srv #(
   parameter int NCH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           take_i,
   input  logic [NCH-1:0] grant_i,
   input  logic           reti_i,
   output logic [NCH-1:0] srv_o
);
   logic [NCH-1:0] top_srv;
   logic [NCH-1:0] set_v;
   logic [NCH-1:0] clr_v;

   assign top_srv = srv_o & (~srv_o + NCH'(1));
   assign set_v   = take_i ? grant_i : '0;
   assign clr_v   = reti_i ? top_srv : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)
         srv_o <= '0;
      else
         srv_o <= (srv_o & ~clr_v) | set_v;
   end

   // R10: the acknowledged channel enters service
   assert_take_marks_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> ((srv_o & $past(grant_i)) != '0));

   // R9: a return without a concurrent acknowledge drops exactly one mark
   assert_reti_one_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (reti_i && !take_i && (srv_o != '0)) |=>
         ($countones(srv_o) + 1 == $countones($past(srv_o))));
endmodule

// File: rtl/ictl_daisy.sv
module ictl_daisy
   import ictl_pkg::*;
#(
   parameter int NCH   = 4,
   parameter int VEC_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NCH-1:0]          zc_i,
   input  logic [NCH-1:0]          ena_i,
   input  logic                    iei_i,
   input  logic                    ack_i,
   input  logic                    reti_i,
   input  logic [VEC_W-SLOT_W-2:0] vec_hi_i,
   output logic                    int_n_o,
   output logic                    ieo_o,
   output logic [VEC_W-1:0]        vec_o,
   output logic                    vec_oe_o
);
   generate
      if (NCH < 1 || NCH > MAX_CH) begin : g_bad_nch
         $error("ictl_daisy: NCH must lie in 1..%0d", MAX_CH);
      end
      if (VEC_W < SLOT_W + 2) begin : g_bad_vec
         $error("ictl_daisy: VEC_W too small for the slot field");
      end
   endgenerate

   logic [NCH-1:0]    pend;
   logic [NCH-1:0]    srv;
   logic [NCH-1:0]    grant;
   logic              any;
   logic [SLOT_W-1:0] idx;
   logic              take;
   logic              reti_q;

   assign take   = ack_i & iei_i & any;
   assign reti_q = reti_i & iei_i;

   ictl_req_latch #(.NCH(NCH)) u_req (
      .clk    (clk),
      .rst_n  (rst_n),
      .zc_i   (zc_i),
      .ena_i  (ena_i),
      .clr_i  (take ? grant : '0),
      .pend_o (pend)
   );

   ictl_prio #(.NCH(NCH)) u_prio (
      .clk     (clk),
      .rst_n   (rst_n),
      .pend_i  (pend),
      .srv_i   (srv),
      .grant_o (grant),
      .any_o   (any),
      .idx_o   (idx)
   );

   ictl_srv #(.NCH(NCH)) u_srv (
      .clk     (clk),
      .rst_n   (rst_n),
      .take_i  (take),
      .grant_i (grant),
      .reti_i  (reti_q),
      .srv_o   (srv)
   );

   assign int_n_o  = ~(iei_i & any);
   assign ieo_o    = iei_i & ~(|pend) & ~(|srv);
   assign vec_oe_o = take;
   assign vec_o    = take ? {vec_hi_i, idx, 1'b0} : '0;

   // R7: a passed-on enable and an own request never coexist
   assert_ieo_quiet_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      ieo_o |-> int_n_o);

   // R6: a low incoming enable silences the whole group
   assert_iei_gate_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !iei_i |-> (int_n_o && !vec_oe_o && !ieo_o));

   // R5: a driven vector always has bit 0 clear and the programmed upper field
   assert_vec_shape_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      vec_oe_o |-> (!vec_o[0] && vec_o[VEC_W-1:SLOT_W+1] == vec_hi_i));

   // R11: a vector appears only with a request standing
   assert_vec_with_req_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      vec_oe_o |-> (!int_n_o && ack_i));
endmodule

// File: tb/sim_ictl_daisy.sv
module sim_ictl_daisy;
   localparam int NCH   = 4;
   localparam int VEC_W = 8;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic             rst_n;
   logic [NCH-1:0]   zc, ena;
   logic             iei, ack, reti;
   logic [VEC_W-4:0] vhi;
   logic             int_n, ieo, vec_oe;
   logic [VEC_W-1:0] vec;

   logic [NCH-1:0]   m_pend, m_srv;
   int               n_chk = 0;
   int               n_fail = 0;
   bit               done = 1'b0;

   ictl_daisy #(.NCH(NCH), .VEC_W(VEC_W)) u0 (
      .clk(clk), .rst_n(rst_n), .zc_i(zc), .ena_i(ena), .iei_i(iei),
      .ack_i(ack), .reti_i(reti), .vec_hi_i(vhi), .int_n_o(int_n),
      .ieo_o(ieo), .vec_o(vec), .vec_oe_o(vec_oe)
   );

   function automatic int m_idx();
      for (int k = 0; k < NCH; k++) begin
         if (m_srv[k]) return -1;
         if (m_pend[k]) return k;
      end
      return -1;
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic check_out(string tag);
      int g;
      bit e_oe;
      g    = m_idx();
      e_oe = ack && iei && (g >= 0);
      chk({tag, " int_n"}, int'(int_n), int'(!(iei && g >= 0)));
      chk({tag, " R7 ieo"}, int'(ieo), int'(iei && m_pend == 0 && m_srv == 0));
      chk({tag, " R11 vec_oe"}, int'(vec_oe), int'(e_oe));
      if (e_oe)
         chk({tag, " R5 vec"}, int'(vec), int'({vhi, 2'(g), 1'b0}));
      else
         chk({tag, " R11 vec idle"}, int'(vec), 0);
   endtask

   task automatic drive(logic [NCH-1:0] z, logic [NCH-1:0] e, logic ii, logic a, logic r);
      zc = z; ena = e; iei = ii; ack = a; reti = r;
      #1;
   endtask

   task automatic tick(string tag);
      int g;
      logic [NCH-1:0] top;
      check_out(tag);
      @(posedge clk);
      g   = m_idx();
      top = m_srv & (~m_srv + 4'd1);
      if (ack && iei && g >= 0) begin
         m_pend[g] = 1'b0;
         if (reti && iei) m_srv = m_srv & ~top;
         m_srv[g] = 1'b1;
      end else if (reti && iei) begin
         m_srv = m_srv & ~top;
      end
      m_pend = m_pend | (zc & ena);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int unsigned r;
      rst_n = 1'b0; m_pend = '0; m_srv = '0; vhi = 5'b10110;
      zc = '0; ena = '0; iei = 1'b1; ack = 1'b0; reti = 1'b0;
      r = $urandom(32'd7351);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      drive(4'b0000, 4'b1111, 1, 0, 0);
      chk("R1 int_n", int'(int_n), 1);
      chk("R1 ieo", int'(ieo), 1);
      chk("R1 vec_oe", int'(vec_oe), 0);
      tick("R1");

      // two enabled channels fire together
      drive(4'b1010, 4'b1111, 1, 0, 0); tick("R2");
      drive(4'b0000, 4'b1111, 1, 0, 0);
      chk("R2 int_n low", int'(int_n), 0);
      tick("R2");
      drive(4'b0000, 4'b1111, 1, 1, 0);
      chk("R4 R5 vec ch1", int'(vec), 8'hB2);
      tick("R4");
      drive(4'b0000, 4'b1111, 1, 0, 0);
      chk("R8 ch3 blocked", int'(int_n), 1);
      chk("R7 ieo low", int'(ieo), 0);
      tick("R8");
      // higher priority nests over ch1
      drive(4'b0001, 4'b1111, 1, 0, 0); tick("R8");
      drive(4'b0000, 4'b1111, 1, 0, 0);
      chk("R8 ch0 nests", int'(int_n), 0);
      tick("R8");
      drive(4'b0000, 4'b1111, 1, 1, 0);
      chk("R4 R5 vec ch0", int'(vec), 8'hB0);
      tick("R4");
      drive(4'b0000, 4'b1111, 1, 0, 1); tick("R9");
      drive(4'b0000, 4'b1111, 0, 0, 1); tick("R6 R9");
      drive(4'b0000, 4'b1111, 1, 0, 0);
      chk("R9 reti ignored without iei", int'(int_n), 1);
      tick("R9");
      drive(4'b0000, 4'b1111, 1, 0, 1); tick("R9");
      drive(4'b0000, 4'b1111, 1, 0, 0);
      chk("R9 ch3 released", int'(int_n), 0);
      tick("R9");
      drive(4'b0000, 4'b1111, 1, 1, 0);
      chk("R5 vec ch3", int'(vec), 8'hB6);
      tick("R5");
      drive(4'b0000, 4'b1111, 1, 0, 1); tick("R9");
      drive(4'b0000, 4'b1111, 1, 0, 0);
      chk("R7 ieo back", int'(ieo), 1);
      tick("R7");

      // disabled channel
      drive(4'b1000, 4'b0111, 1, 0, 0); tick("R3");
      drive(4'b0000, 4'b0111, 1, 0, 0);
      chk("R3 int_n", int'(int_n), 1);
      chk("R3 ieo", int'(ieo), 1);
      tick("R3");

      // acknowledge while iei low is ignored
      drive(4'b0100, 4'b1111, 1, 0, 0); tick("R6");
      drive(4'b0000, 4'b1111, 0, 1, 0);
      chk("R6 vec_oe", int'(vec_oe), 0);
      chk("R6 int_n", int'(int_n), 1);
      tick("R6");
      drive(4'b0000, 4'b1111, 1, 0, 0);
      chk("R6 still pending", int'(int_n), 0);
      tick("R6");

      // same-cycle acknowledge and new zero-count on ch2
      drive(4'b0100, 4'b1111, 1, 1, 0); tick("R10");
      drive(4'b0000, 4'b1111, 1, 0, 0);
      chk("R10 self blocked", int'(int_n), 1);
      tick("R10");
      drive(4'b0000, 4'b1111, 1, 0, 1); tick("R10");
      drive(4'b0000, 4'b1111, 1, 0, 0);
      chk("R10 kept pending", int'(int_n), 0);
      tick("R10");
      drive(4'b0000, 4'b1111, 1, 1, 0); tick("R10");
      drive(4'b0000, 4'b1111, 1, 0, 1); tick("R9");

      // constrained random traffic
      for (int c = 0; c < 3000; c++) begin
         logic [NCH-1:0] e;
         e = ena;
         if ($urandom % 16 == 0) e = 4'($urandom);
         if ($urandom % 64 == 0) vhi = 5'($urandom);
         drive(4'($urandom) & 4'($urandom) & 4'($urandom), e,
               ($urandom % 8) != 0, ($urandom % 5) == 0, ($urandom % 6) == 0);
         tick("R2 R4 R8");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule